// File: doc/BRIEF.md
# Dual-Port Semaphore Token Unit

This block keeps a small bank of hardware lock flags that two independent ports share. Each flag guards one shared resource. A port claims a flag by writing a 0 to it and hands it back by writing a 1. A read returns that flag as the reading port sees it: all zeros if this port owns the token, and all ones otherwise.

A claim that arrives while the other port holds the flag is not lost. It is latched as a pending request. When the holder releases the flag, the token passes straight to the waiting port with no retry. A waiting port can withdraw its request by writing a 1. Writes take effect on the rising clock edge. Reads are combinational from the registered flag state, so a read shows the state left by the most recent edge.

Top module: `sem_token_unit`

## Requirements
- R1: After reset all eight flags are free with nothing pending, so both ports read 16'hFFFF from every flag.
- R2: A port reaches the flags only while its select input `*_sem_n` is 0 and its `*_ce_n` is 1. A write attempted outside that window changes no flag state. An unselected port's read bus is all zeros.
- R3: The 3-bit address picks one of eight flags. A write to one flag leaves the other seven unchanged.
- R4: A write uses only the single datum bit `*_wdat`. A read drives the same view bit onto all 16 read bits, so the bus is 16'h0000 or 16'hFFFF.
- R5: Writing 0 to a free flag gives that port the token. That port then reads 16'h0000 and the other port reads 16'hFFFF.
- R6: Writing 0 to a flag the other port holds changes nothing that either port can read. The request stays pending.
- R7: When the holder writes 1 while the other port has a request pending, the other port owns the flag after that edge.
- R8: When the holder writes 1 with no request pending, the flag becomes free and both ports read 16'hFFFF.
- R9: When both ports write 0 to the same free flag on the same edge, the left port gets the token and the right request stays pending.
- R10: A port that writes 1 while its request is still pending cancels that request. A later release by the holder then leaves the flag free.
- R11: A holder that writes 0 again keeps the token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sem_n | input | 1 | Left flag-bank select, active low |
| l_ce_n | input | 1 | Left main-array enable; must be 1 for flag access |
| l_we_n | input | 1 | Left write strobe, active low |
| l_addr | input | 3 | Left flag index |
| l_wdat | input | 1 | Left write datum (0 claim, 1 release) |
| l_rdat | output | 16 | Left view of the addressed flag |
| r_sem_n | input | 1 | Right flag-bank select, active low |
| r_ce_n | input | 1 | Right main-array enable; must be 1 for flag access |
| r_we_n | input | 1 | Right write strobe, active low |
| r_addr | input | 3 | Right flag index |
| r_wdat | input | 1 | Right write datum (0 claim, 1 release) |
| r_rdat | output | 16 | Right view of the addressed flag |

## Verification
The bench targets the same-edge collisions and the other contention cases:
- Both ports claim one free flag on the same edge. A design without left priority would grant both or neither.
- One port releases while the other claims on the same edge. The token must land on the claimant and not go free.
- A pending request is cancelled before the release. A design that forgot the cancellation would hand the token to a port that no longer wants it.
- Writes are attempted with the chip enable low. A design with a wrong gate would move tokens on ordinary memory cycles.

A long pseudo-random sweep checks every flag from both sides after each edge. This exposes any cross-talk between flag indexes.

// File: rtl/sem_token_pkg.sv
package sem_token_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    // want_* is set while a side wants the token, held or waiting
    typedef struct packed {
        owner_e owner;
        logic   want_l;
        logic   want_r;
    } flag_t;

    localparam flag_t FLAG_RESET = '{owner: OWN_NONE, want_l: 1'b0, want_r: 1'b0};

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 3
) (
    input  logic               sem_n,
    input  logic               ce_n,
    input  logic               we_n,
    input  logic [ADDR_W-1:0]  addr,
    output logic               sel,
    output logic [NUM_SEM-1:0] wr_hit
);

    logic wr_act;

    always_comb begin
        sel    = ~sem_n & ce_n;
        wr_act = sel & ~we_n;
    end

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_hit
        assign wr_hit[g] = wr_act && (addr == ADDR_W'(g));
    end

endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
    import sem_token_pkg::*;
(
    input  flag_t cur,
    input  logic  wr_l,
    input  logic  d_l,
    input  logic  wr_r,
    input  logic  d_r,
    output flag_t nxt
);

    logic want_l_d;
    logic want_r_d;

    always_comb begin
        want_l_d = wr_l ? ~d_l : cur.want_l;
        want_r_d = wr_r ? ~d_r : cur.want_r;

        nxt.want_l = want_l_d;
        nxt.want_r = want_r_d;
        nxt.owner  = cur.owner;

        unique case (cur.owner)
            OWN_NONE: begin
                if (want_l_d)      nxt.owner = OWN_LEFT;
                else if (want_r_d) nxt.owner = OWN_RIGHT;
            end
            OWN_LEFT: begin
                if (!want_l_d) nxt.owner = want_r_d ? OWN_RIGHT : OWN_NONE;
            end
            OWN_RIGHT: begin
                if (!want_r_d) nxt.owner = want_l_d ? OWN_LEFT : OWN_NONE;
            end
            default: nxt.owner = OWN_NONE;
        endcase
    end

endmodule

// File: rtl/sem_view_mux.sv
module sem_view_mux #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 16
) (
    input  logic               sel,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_SEM-1:0] held_me,
    output logic [DATA_W-1:0]  rdat
);

    always_comb begin
        rdat = '0;
        if (sel) rdat = {DATA_W{~held_me[addr]}};
    end

endmodule

// File: rtl/sem_token_unit.sv
module sem_token_unit
    import sem_token_pkg::*;
#(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 16,
    localparam int ADDR_W = $clog2(NUM_SEM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sem_n,
    input  logic              l_ce_n,
    input  logic              l_we_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_wdat,
    output logic [DATA_W-1:0] l_rdat,
    input  logic              r_sem_n,
    input  logic              r_ce_n,
    input  logic              r_we_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_wdat,
    output logic [DATA_W-1:0] r_rdat
);

    flag_t flag_q [NUM_SEM];
    flag_t flag_d [NUM_SEM];

    logic               l_sel;
    logic               r_sel;
    logic [NUM_SEM-1:0] l_hit;
    logic [NUM_SEM-1:0] r_hit;
    logic [NUM_SEM-1:0] held_l;
    logic [NUM_SEM-1:0] held_r;
    logic [NUM_SEM-1:0] pend_l;
    logic [NUM_SEM-1:0] pend_r;

    sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) i_dec_l (
        .sem_n (l_sem_n),
        .ce_n  (l_ce_n),
        .we_n  (l_we_n),
        .addr  (l_addr),
        .sel   (l_sel),
        .wr_hit(l_hit)
    );

    sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) i_dec_r (
        .sem_n (r_sem_n),
        .ce_n  (r_ce_n),
        .we_n  (r_we_n),
        .addr  (r_addr),
        .sel   (r_sel),
        .wr_hit(r_hit)
    );

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_flag
        sem_flag_cell i_cell (
            .cur (flag_q[g]),
            .wr_l(l_hit[g]),
            .d_l (l_wdat),
            .wr_r(r_hit[g]),
            .d_r (r_wdat),
            .nxt (flag_d[g])
        );

        assign held_l[g] = (flag_q[g].owner == OWN_LEFT);
        assign held_r[g] = (flag_q[g].owner == OWN_RIGHT);
        assign pend_l[g] = flag_q[g].want_l && !held_l[g];
        assign pend_r[g] = flag_q[g].want_r && !held_r[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SEM; i++) flag_q[i] <= FLAG_RESET;
        end else begin
            for (int i = 0; i < NUM_SEM; i++) flag_q[i] <= flag_d[i];
        end
    end

    sem_view_mux #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_view_l (
        .sel    (l_sel),
        .addr   (l_addr),
        .held_me(held_l),
        .rdat   (l_rdat)
    );

    sem_view_mux #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_view_r (
        .sel    (r_sel),
        .addr   (r_addr),
        .held_me(held_r),
        .rdat   (r_rdat)
    );

endmodule

// File: rtl/sem_token_checker.sv
module sem_token_checker #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l_sem_n,
    input logic               l_ce_n,
    input logic               l_we_n,
    input logic [ADDR_W-1:0]  l_addr,
    input logic               l_wdat,
    input logic [DATA_W-1:0]  l_rdat,
    input logic               r_sem_n,
    input logic               r_ce_n,
    input logic               r_we_n,
    input logic [ADDR_W-1:0]  r_addr,
    input logic               r_wdat,
    input logic [DATA_W-1:0]  r_rdat,
    input logic [NUM_SEM-1:0] held_l,
    input logic [NUM_SEM-1:0] held_r,
    input logic [NUM_SEM-1:0] pend_l,
    input logic [NUM_SEM-1:0] pend_r
);

    logic l_on;
    logic r_on;
    logic l_wr;
    logic r_wr;

    assign l_on = !l_sem_n && l_ce_n;
    assign r_on = !r_sem_n && r_ce_n;
    assign l_wr = l_on && !l_we_n;
    assign r_wr = r_on && !r_we_n;

    AST_UNSEL_QUIET_L: assert property (@(posedge clk) disable iff (!rst_n) !l_on |-> l_rdat == '0); // R2
    AST_UNSEL_QUIET_R: assert property (@(posedge clk) disable iff (!rst_n) !r_on |-> r_rdat == '0); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_wr && !r_wr) |=> ($stable(held_l) && $stable(held_r) && $stable(pend_l) && $stable(pend_r))); // R2
    AST_WIDE_READ_L: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rdat == '0) || (l_rdat == '1) || !l_on); // R4
    AST_WIDE_READ_R: assert property (@(posedge clk) disable iff (!rst_n)
        (r_rdat == '0) || (r_rdat == '1) || !r_on); // R4
    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n) (held_l & held_r) == '0); // R5
    AST_NO_DUAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (l_on && r_on && l_addr == r_addr) |-> !(l_rdat[0] == 1'b0 && r_rdat[0] == 1'b0)); // R5
    AST_FREE_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((~(held_l | held_r)) & (pend_l | pend_r)) == '0); // R10

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_chk
        AST_HANDOFF_TO_R: assert property (@(posedge clk) disable iff (!rst_n)
            (held_l[g] && pend_r[g] && l_wr && l_addr == ADDR_W'(g) && l_wdat
             && !(r_wr && r_addr == ADDR_W'(g))) |=> held_r[g]); // R7
        AST_HANDOFF_TO_L: assert property (@(posedge clk) disable iff (!rst_n)
            (held_r[g] && pend_l[g] && r_wr && r_addr == ADDR_W'(g) && r_wdat
             && !(l_wr && l_addr == ADDR_W'(g))) |=> held_l[g]); // R7
    end

endmodule

bind sem_token_unit sem_token_checker #(
    .NUM_SEM(NUM_SEM),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) i_sem_token_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .l_sem_n(l_sem_n),
    .l_ce_n (l_ce_n),
    .l_we_n (l_we_n),
    .l_addr (l_addr),
    .l_wdat (l_wdat),
    .l_rdat (l_rdat),
    .r_sem_n(r_sem_n),
    .r_ce_n (r_ce_n),
    .r_we_n (r_we_n),
    .r_addr (r_addr),
    .r_wdat (r_wdat),
    .r_rdat (r_rdat),
    .held_l (held_l),
    .held_r (held_r),
    .pend_l (pend_l),
    .pend_r (pend_r)
);

// File: tb/test_sem_token_unit.sv
`timescale 1ns/10ps
module test_sem_token_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        l_sem_n = 1'b1, l_ce_n = 1'b1, l_we_n = 1'b1, l_wdat = 1'b1;
    logic        r_sem_n = 1'b1, r_ce_n = 1'b1, r_we_n = 1'b1, r_wdat = 1'b1;
    logic [2:0]  l_addr = '0, r_addr = '0;
    logic [15:0] l_rdat, r_rdat;

    int checks = 0;
    int failures = 0;

    // bench model: owner 0 free, 1 left, 2 right; waiting flags per side
    int own [8];
    bit wq [1:2][8];

    always #2.5 clk = ~clk;

    sem_token_unit i_sem_token_unit (
        .clk, .rst_n,
        .l_sem_n, .l_ce_n, .l_we_n, .l_addr, .l_wdat, .l_rdat,
        .r_sem_n, .r_ce_n, .r_we_n, .r_addr, .r_wdat, .r_rdat
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic m_write(input int side, input int a, input bit d);
        int other;
        other = 3 - side;
        if (!d) begin
            if (own[a] == 0)          own[a] = side;
            else if (own[a] != side)  wq[side][a] = 1'b1;
        end else begin
            if (own[a] == side) begin
                if (wq[other][a]) begin own[a] = other; wq[other][a] = 1'b0; end
                else own[a] = 0;
            end else wq[side][a] = 1'b0;
        end
    endtask

    function automatic logic [15:0] view(input int side, input int a);
        return (own[a] == side) ? 16'h0000 : 16'hFFFF;
    endfunction

    task automatic idle_pins();
        l_sem_n = 1'b1; l_ce_n = 1'b1; l_we_n = 1'b1; l_wdat = 1'b1;
        r_sem_n = 1'b1; r_ce_n = 1'b1; r_we_n = 1'b1; r_wdat = 1'b1;
    endtask

    // one edge; en bits request a write, gate bits break the access window
    task automatic op(input bit le, input int la, input bit ld, input bit lgate,
                      input bit re, input int ra, input bit rd, input bit rgate);
        @(negedge clk);
        l_sem_n = ~le; l_ce_n = ~lgate; l_we_n = ~le; l_addr = 3'(la); l_wdat = ld;
        r_sem_n = ~re; r_ce_n = ~rgate; r_we_n = ~re; r_addr = 3'(ra); r_wdat = rd;
        @(posedge clk);
        #1;
        idle_pins();
        if (le && !lgate) m_write(1, la, ld);
        if (re && !rgate) m_write(2, ra, rd);
    endtask

    task automatic read_one(input int a, input string tag);
        l_sem_n = 1'b0; l_ce_n = 1'b1; l_we_n = 1'b1; l_addr = 3'(a);
        r_sem_n = 1'b0; r_ce_n = 1'b1; r_we_n = 1'b1; r_addr = 3'(a);
        #0.2;
        chk(l_rdat === view(1, a), {tag, " left"}, l_rdat, view(1, a));
        chk(r_rdat === view(2, a), {tag, " right"}, r_rdat, view(2, a));
        idle_pins();
        #0.1;
    endtask

    task automatic scan(input string tag);
        for (int a = 0; a < 8; a++) read_one(a, tag);
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < 8; i++) begin own[i] = 0; wq[1][i] = 1'b0; wq[2][i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        scan("R1 reset free");
        #0.2;
        chk(l_rdat === 16'h0, "R2 unselected left bus", l_rdat, 16'h0);
        chk(r_rdat === 16'h0, "R2 unselected right bus", r_rdat, 16'h0);

        // claim/deny/handoff/release sequence on flag 3
        op(1, 3, 0, 0, 0, 0, 1, 0); read_one(3, "R5 left claims free");
        op(0, 0, 1, 0, 1, 3, 0, 0); read_one(3, "R6 right denied");
        op(1, 3, 1, 0, 0, 0, 1, 0); read_one(3, "R7 handoff to right");
        op(1, 3, 0, 0, 0, 0, 1, 0); read_one(3, "R6 left denied");
        op(0, 0, 1, 0, 1, 3, 1, 0); read_one(3, "R7 handoff to left");
        op(1, 3, 1, 0, 0, 0, 1, 0); read_one(3, "R8 release to free");
        scan("R3 other flags untouched");

        // R4: replicated read on a held flag
        op(0, 0, 1, 0, 1, 1, 0, 0);
        read_one(1, "R4 wide read");
        // R11: holder rewrites 0
        op(0, 0, 1, 0, 1, 1, 0, 0); read_one(1, "R11 holder keeps");
        op(0, 0, 1, 0, 1, 1, 1, 0); read_one(1, "R8 right release");

        // R9: tie on flag 5, then left release hands to right
        op(1, 5, 0, 0, 1, 5, 0, 0); read_one(5, "R9 tie left wins");
        op(1, 5, 1, 0, 0, 0, 1, 0); read_one(5, "R9 pending right granted");
        op(0, 0, 1, 0, 1, 5, 1, 0); read_one(5, "R8 free after right release");

        // R10: cancel pending on flag 6
        op(1, 6, 0, 0, 0, 0, 1, 0);
        op(0, 0, 1, 0, 1, 6, 0, 0);
        op(0, 0, 1, 0, 1, 6, 1, 0); read_one(6, "R10 cancel keeps left");
        op(1, 6, 1, 0, 0, 0, 1, 0); read_one(6, "R10 free after cancel");

        // R2: gated writes do nothing
        op(1, 2, 0, 1, 1, 4, 0, 1); scan("R2 gated write ignored");

        // same-edge release and claim
        op(1, 0, 0, 0, 0, 0, 1, 0);
        op(1, 0, 1, 0, 1, 0, 0, 0); read_one(0, "R7 same-edge release and claim");

        // pseudo-random sweep
        lfsr = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            for (int k = 0; k < 16; k++)
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            op(lfsr[0], int'(lfsr[3:1]), lfsr[4], lfsr[5] & lfsr[6] & lfsr[14],
               lfsr[7], lfsr[15] ? int'(lfsr[3:1]) : int'(lfsr[10:8]), lfsr[11],
               lfsr[12] & lfsr[13] & lfsr[2]);
            scan("R3 sweep");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule